// File: doc/BRIEF.md
# ALU Status Flag Register

This block derives and keeps the condition flags of an 8-bit arithmetic unit, together with two flags that record power-down and watchdog events. When an ALU operation completes, the surrounding datapath presents the two operands, the result, a two-bit operation class and a write strobe. On the next clock edge the block updates the carry, half-carry, zero and signed-overflow flags, but only those that the operation class owns.

Subtraction is treated as A + ~B + 1. The carry flags therefore mean "no borrow" on a subtract. A rotate through carry loads the carry flag from the bit that the datapath shifted out, and the `carry` output feeds that bit back into the next rotate.

Four single-cycle system strobes maintain the power-down and time-out flags: power-up, watchdog clear, halt and watchdog expiry. These flags are independent of the ALU flags.

Top module: `alu_status_reg`

## Requirements
- R1: `status` bit layout: bit 0 carry, bit 1 half-carry, bit 2 zero, bit 3 overflow, bit 4 power-down, bit 5 time-out. Bits 7:6 always read 0. Synchronous active-low reset clears every bit.
- R2: Add (`op_kind`=0, `op_wr`=1): carry becomes the carry out of bit 7 of A+B in the cycle after the write.
- R3: Subtract (`op_kind`=1): carry becomes 1 when A>=B (unsigned, no borrow) and 0 when a borrow occurs.
- R4: Half-carry becomes the carry out of bit 3 on add. On subtract it becomes 1 when A[3:0]>=B[3:0] (no borrow into the low nibble).
- R5: Zero becomes 1 exactly when `result` is 0, on add, subtract and logical operations.
- R6: Overflow becomes the XOR of the carry into bit 7 and the carry out of bit 7 of the effective adder, on add and subtract.
- R7: Rotate (`op_kind`=2) loads carry from `rot_bit` and leaves half-carry, zero and overflow unchanged.
- R8: Logical (`op_kind`=3) updates only zero and leaves carry, half-carry and overflow unchanged.
- R9: With `op_wr`=0, bits 3:0 hold their values.
- R10: Power-down flag is cleared by `pwr_up` or `wdt_clr` and set by `halt`. A clear in the same cycle as `halt` wins.
- R11: Time-out flag is set by `wdt_tmo` and cleared by `pwr_up`, `wdt_clr` or `halt`. `wdt_tmo` wins over any clear in the same cycle.
- R12: The `carry` output always equals `status` bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | First ALU operand |
| op_b | input | 8 | Second ALU operand (subtrahend on subtract) |
| result | input | 8 | ALU result, used for the zero flag |
| op_kind | input | 2 | 0 add, 1 subtract, 2 rotate through carry, 3 logical |
| op_wr | input | 1 | Commit flags of the current operation |
| rot_bit | input | 1 | Bit shifted out by a rotate through carry |
| pwr_up | input | 1 | Power-up event strobe |
| wdt_clr | input | 1 | Watchdog-clear event strobe |
| halt | input | 1 | Halt event strobe |
| wdt_tmo | input | 1 | Watchdog expiry strobe |
| status | output | 8 | Status register value |
| carry | output | 1 | Carry flag, fed back to rotates |

## Verification
The hardest cases to reach from the ports are the flag-retention rules. A logical or rotate operation must be shown to leave a flag untouched, and that only proves something when the flag already holds a value the operation would otherwise change. The stimulus therefore first uses an arithmetic operation to preload a known non-zero pattern, for example 0x7F+0x01, which sets both half-carry and overflow. Logical and rotate operations follow with results chosen so that a wrongful update would flip a bit. The same-cycle collisions of halt, clear and expiry strobes are driven as explicit pairs. Add and subtract are swept over every A and a stride of B that includes 0 and 0xFF.

// File: rtl/stat_pkg.sv
// Shared definitions for the ALU status register: operation classes and
// the bit positions of every flag inside the 8-bit status word.
package stat_pkg;
    typedef enum logic [1:0] {
        OPK_ADD   = 2'd0,
        OPK_SUB   = 2'd1,
        OPK_ROT   = 2'd2,
        OPK_LOGIC = 2'd3
    } op_kind_e;

    localparam int STAT_W  = 8;
    localparam int BIT_C   = 0;
    localparam int BIT_AC  = 1;
    localparam int BIT_Z   = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_PD  = 4;
    localparam int BIT_TO  = 5;
endpackage

// File: rtl/arith_flags.sv
// Combinational flag generator. It rebuilds the adder carries from the
// operands so the flags are independent of how the datapath formed its
// result. Assumes subtract is A + ~B + 1 (carries mean "no borrow").
module arith_flags #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    output logic              c_out,
    output logic              hc_out,
    output logic              ov_out
);
    localparam int LOW_W = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    nib_sum;
    logic [LOW_W:0]    low_sum;

    // Effective adder: invert B and inject carry-in for subtraction.
    always_comb begin
        b_eff    = is_sub ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
        nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, is_sub};
        low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, is_sub};
    end

    // Flag extraction: carry out, nibble carry, and carry-in XOR carry-out at the MSB.
    always_comb begin
        c_out  = full_sum[DATA_W];
        hc_out = nib_sum[NIB_W];
        ov_out = low_sum[LOW_W] ^ full_sum[DATA_W];
    end
endmodule

// File: rtl/event_flags.sv
// Power-down and time-out flag holder driven by single-cycle system
// strobes. Assumes each strobe is high for one clock per event.
module event_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic wdt_clr,
    input  logic halt,
    input  logic wdt_tmo,
    output logic pd_flag,
    output logic to_flag
);
    logic clr_any;

    // Combined clear request shared by both flags.
    always_comb clr_any = pwr_up | wdt_clr;

    // Power-down flag: a clear outranks halt.
    always_ff @(posedge clk) begin
        if (!rst_n)       pd_flag <= 1'b0;
        else if (clr_any) pd_flag <= 1'b0;
        else if (halt)    pd_flag <= 1'b1;
    end

    // Time-out flag: expiry outranks every clear, halt included.
    always_ff @(posedge clk) begin
        if (!rst_n)               to_flag <= 1'b0;
        else if (wdt_tmo)         to_flag <= 1'b1;
        else if (clr_any || halt) to_flag <= 1'b0;
    end
endmodule

// File: rtl/alu_status_reg.sv
// Top of the status register. It registers the arithmetic flags selected
// by the operation class and assembles the 8-bit status word. Assumes
// `result` is valid whenever `op_wr` is high.
module alu_status_reg
    import stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic [1:0]        op_kind,
    input  logic              op_wr,
    input  logic              rot_bit,
    input  logic              pwr_up,
    input  logic              wdt_clr,
    input  logic              halt,
    input  logic              wdt_tmo,
    output logic [STAT_W-1:0] status,
    output logic              carry
);
    localparam int NIB_W = DATA_W / 2;

    op_kind_e kind;
    logic     c_new, hc_new, ov_new;
    logic     c_q, hc_q, z_q, ov_q;
    logic     pd_q, to_q;
    logic     is_arith;

    // Decode the operation class.
    always_comb begin
        kind     = op_kind_e'(op_kind);
        is_arith = (kind == OPK_ADD) || (kind == OPK_SUB);
    end

    arith_flags #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
        .a      (op_a),
        .b      (op_b),
        .is_sub (kind == OPK_SUB),
        .c_out  (c_new),
        .hc_out (hc_new),
        .ov_out (ov_new)
    );

    event_flags u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_up  (pwr_up),
        .wdt_clr (wdt_clr),
        .halt    (halt),
        .wdt_tmo (wdt_tmo),
        .pd_flag (pd_q),
        .to_flag (to_q)
    );

    // Carry: arithmetic carry or rotated-out bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         c_q <= 1'b0;
        else if (op_wr && is_arith)         c_q <= c_new;
        else if (op_wr && kind == OPK_ROT)  c_q <= rot_bit;
    end

    // Half-carry and overflow: arithmetic operations only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q <= 1'b0;
            ov_q <= 1'b0;
        end else if (op_wr && is_arith) begin
            hc_q <= hc_new;
            ov_q <= ov_new;
        end
    end

    // Zero: every class except rotate.
    always_ff @(posedge clk) begin
        if (!rst_n)                        z_q <= 1'b0;
        else if (op_wr && kind != OPK_ROT) z_q <= (result == '0);
    end

    // Status word assembly; unused upper bits tied low.
    always_comb begin
        status         = '0;
        status[BIT_C]  = c_q;
        status[BIT_AC] = hc_q;
        status[BIT_Z]  = z_q;
        status[BIT_OV] = ov_q;
        status[BIT_PD] = pd_q;
        status[BIT_TO] = to_q;
        carry          = c_q;
    end
endmodule

// File: rtl/status_chk.sv
// Property checker for alu_status_reg, attached through bind below.
// Observes ports only.
module status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] result,
    input logic [1:0] op_kind,
    input logic       op_wr,
    input logic       rot_bit,
    input logic       pwr_up,
    input logic       wdt_clr,
    input logic       halt,
    input logic       wdt_tmo,
    input logic [7:0] status,
    input logic       carry
);
    p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00);

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_kind != 2'd2) |=> (status[2] == ($past(result) == 8'h00)));

    p_rot_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_kind == 2'd2) |=> (status[0] == $past(rot_bit)) && $stable(status[3:1]));

    p_logic_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_kind == 2'd3) |=> $stable(status[0]) && $stable(status[1]) && $stable(status[3]));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_wr |=> $stable(status[3:0]));

    p_pd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up || wdt_clr) |=> !status[4]);

    p_pd_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !pwr_up && !wdt_clr) |=> status[4]);

    p_tmo_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> status[5]);

    p_to_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_tmo && (pwr_up || wdt_clr || halt)) |=> !status[5]);

    p_carry_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
        carry == status[0]);
endmodule

bind alu_status_reg status_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .result  (result),
    .op_kind (op_kind),
    .op_wr   (op_wr),
    .rot_bit (rot_bit),
    .pwr_up  (pwr_up),
    .wdt_clr (wdt_clr),
    .halt    (halt),
    .wdt_tmo (wdt_tmo),
    .status  (status),
    .carry   (carry)
);

// File: tb/sim_alu_status_reg.sv
module sim_alu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0, result = '0;
    logic [1:0] op_kind = '0;
    logic       op_wr = 1'b0, rot_bit = 1'b0;
    logic       pwr_up = 1'b0, wdt_clr = 1'b0, halt = 1'b0, wdt_tmo = 1'b0;
    logic [7:0] status;
    logic       carry;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result),
        .op_kind(op_kind), .op_wr(op_wr), .rot_bit(rot_bit), .pwr_up(pwr_up),
        .wdt_clr(wdt_clr), .halt(halt), .wdt_tmo(wdt_tmo),
        .status(status), .carry(carry)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Apply one ALU write at a negedge and return at the next negedge.
    task automatic alu_op(input logic [1:0] k, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] r, input logic rb);
        op_kind = k; op_a = a; op_b = b; result = r; rot_bit = rb; op_wr = 1'b1;
        @(negedge clk);
        op_wr = 1'b0;
    endtask

    // Pulse system strobes for one cycle.
    task automatic evt(input logic pu, input logic wc, input logic hl, input logic tm);
        pwr_up = pu; wdt_clr = wc; halt = hl; wdt_tmo = tm;
        @(negedge clk);
        pwr_up = 0; wdt_clr = 0; halt = 0; wdt_tmo = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] s;
        logic [7:0] d;
        logic [3:0] e;
        repeat (3) @(negedge clk);
        chk("R1 reset", status, 8'h00);
        chk("R12 reset carry", {7'd0, carry}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Add sweep (R2 R4 R5 R6)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
                s = {1'b0, 8'(a)} + {1'b0, 8'(b)};
                e[0] = s[8];
                e[1] = ({1'b0, 4'(a)} + {1'b0, 4'(b)}) > 5'd15;
                e[2] = (s[7:0] == 8'h00);
                e[3] = (a[7] == b[7]) && (s[7] != a[7]);
                alu_op(2'd0, 8'(a), 8'(b), s[7:0], 1'b0);
                chk("R2/R4/R5/R6 add", {4'd0, status[3:0]}, {4'd0, e});
                chk("R12 add carry", {7'd0, carry}, {7'd0, e[0]});
            end
        end

        // Subtract sweep (R3 R4 R5 R6)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
                d = 8'(a - b);
                e[0] = (a >= b);
                e[1] = (a % 16) >= (b % 16);
                e[2] = (d == 8'h00);
                e[3] = (a[7] != b[7]) && (d[7] != a[7]);
                alu_op(2'd1, 8'(a), 8'(b), d, 1'b0);
                chk("R3/R4/R5/R6 sub", {4'd0, status[3:0]}, {4'd0, e});
            end
        end

        // Preload OV=1 AC=1 C=0 Z=0 via 0x7F+0x01
        alu_op(2'd0, 8'h7F, 8'h01, 8'h80, 1'b0);
        chk("R6 preload", {4'd0, status[3:0]}, 8'h0A);
        // R8: logical with zero result sets Z only
        alu_op(2'd3, 8'hF0, 8'h0F, 8'h00, 1'b1);
        chk("R8 logic zero", {4'd0, status[3:0]}, 8'h0E);
        // R7: rotate loads C, Z kept though result is nonzero
        alu_op(2'd2, 8'h81, 8'h00, 8'h03, 1'b1);
        chk("R7 rotate 1", {4'd0, status[3:0]}, 8'h0F);
        alu_op(2'd2, 8'h00, 8'h00, 8'h00, 1'b0);
        chk("R7 rotate 0", {4'd0, status[3:0]}, 8'h0E);
        alu_op(2'd2, 8'h00, 8'h00, 8'h00, 1'b1);
        // R8: logical nonzero clears Z, keeps C=1 AC=1 OV=1
        alu_op(2'd3, 8'h00, 8'h00, 8'h5A, 1'b0);
        chk("R8 logic nonzero", {4'd0, status[3:0]}, 8'h0B);
        // R9: no write holds flags despite changing inputs
        op_kind = 2'd0; op_a = 8'hFF; op_b = 8'hFF; result = 8'h00; rot_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 idle hold", {4'd0, status[3:0]}, 8'h0B);

        // R10 / R11 events
        evt(0, 0, 1, 0);
        chk("R10 halt sets PD", {2'd0, status[5:4], 4'd0}, 8'h10);
        evt(0, 0, 0, 1);
        chk("R11 timeout", {2'd0, status[5:4], 4'd0}, 8'h30);
        evt(0, 1, 0, 0);
        chk("R10/R11 wdt clear", {2'd0, status[5:4], 4'd0}, 8'h00);
        evt(0, 0, 1, 1);
        chk("R11 timeout beats halt", {2'd0, status[5:4], 4'd0}, 8'h30);
        evt(1, 0, 1, 0);
        chk("R10 pwrup beats halt", {2'd0, status[5:4], 4'd0}, 8'h00);
        evt(0, 0, 0, 1);
        evt(0, 0, 1, 0);
        chk("R11 halt clears TO", {2'd0, status[5:4], 4'd0}, 8'h10);
        evt(0, 1, 1, 1);
        chk("R10/R11 clear+halt+timeout", {2'd0, status[5:4], 4'd0}, 8'h20);
        evt(1, 0, 0, 0);
        chk("R11 pwrup clears TO", {2'd0, status[5:4], 4'd0}, 8'h00);
        chk("R9 events keep ALU flags", {4'd0, status[3:0]}, 8'h0B);
        chk("R1 upper bits", {status[7:6], 6'd0}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule